// File: doc/BRIEF.md
# Pixel Common-Mode Correction and Digit Sparsifier

This block takes one event frame of signed raw pixel samples, delivered in row-major order, and turns it into a sparse stream of digits. For each sample it subtracts a per-pixel pedestal. It then works out a common-mode offset for each band of rows that share a gate. The offset is the truncated average of the pedestal-corrected values. Pixels that are masked, and pixels that carry a hit in this event, are left out of that average. The block subtracts the offset and saturates the result. It then emits only the charges that lie above a programmable threshold, each as a (charge, column, row) digit on a valid/ready stream.

The block works one gate band at a time. It accepts the band's samples and stores their pedestal-corrected values in a local buffer while it accumulates the sum and count for the average. It divides with a sequential divider and then replays the buffer to produce digits. While a band is being divided or replayed, the input is held off. A single-cycle frame-done pulse marks the end of the last band. Pedestals and mask bits are loaded through a write port, one pixel per cycle, and the threshold has a write port of its own. The row and column counts and the band height must be powers of two.

Top module: `pixel_cm_sparsifier`

## Requirements
- R1: After reset, out_valid and frame_done are 0, in_ready is 1, and the threshold holds 3.
- R2: For each pixel, d = raw − pedestal. For each band of GROUP_ROWS rows, the common mode is the sum of d over included pixels divided by their count. The quotient is truncated toward zero. The charge is d minus that common mode.
- R3: A pixel is a hit, and is excluded from the common mode, when d > 4. A pixel with d = 4 is still included.
- R4: A pixel whose mask bit is 1 is excluded from its band's common mode but still produces a digit when its charge passes the threshold.
- R5: When no pixel of a band is included, that band's common mode is 0.
- R6: A digit is emitted only when its charge is strictly greater than the threshold. The threshold is a signed OUT_W-bit value written through thr_we/thr_data.
- R7: Each digit carries the charge, the column (linear index mod COLS) and the row (linear index / COLS). Within a frame, digits leave in row-major order.
- R8: The charge is saturated to the signed OUT_W-bit range before the threshold test and output.
- R9: in_ready is 0 while a band is being divided or replayed, and in particular whenever out_valid is 1. Each band accepts exactly GROUP_ROWS×COLS samples.
- R10: frame_done is a one-cycle pulse that follows the last digit of the last band, after which the block accepts the next frame.
- R11: While out_valid is 1 and out_ready is 0, out_valid and the digit fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for pedestal and mask memory |
| cfg_addr | input | log2(ROWS·COLS) | Pixel linear index (row·COLS + column) |
| cfg_ped | input | RAW_W | Signed pedestal value |
| cfg_mask | input | 1 | 1 excludes the pixel from the common mode |
| thr_we | input | 1 | Threshold write strobe |
| thr_data | input | OUT_W | Signed zero-suppression threshold |
| in_valid | input | 1 | Raw sample valid |
| in_ready | output | 1 | Block accepts a raw sample |
| in_data | input | RAW_W | Signed raw sample, row-major order |
| out_valid | output | 1 | Digit valid |
| out_ready | input | 1 | Consumer accepts digit |
| out_charge | output | OUT_W | Signed saturated corrected charge |
| out_col | output | log2(COLS) | Digit column |
| out_row | output | log2(ROWS) | Digit row |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The assertions assume that pedestal, mask and threshold writes happen only between frames, after frame_done and before the next first sample. The threshold check and the stability checks depend on that. They also assume the consumer never relies on out_valid dropping without a handshake. The bench loads every configuration value while the block is idle and waits for frame_done before it changes anything. It drives raw values chosen so that pedestal plus offset stays inside the signed RAW_W range. It applies backpressure only through out_ready.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  typedef enum logic [2:0] {
    ST_FILL,
    ST_LAST,
    ST_DIV,
    ST_WAIT,
    ST_RD,
    ST_EV,
    ST_OUT
  } pcm_state_e;
endpackage

// File: rtl/pcm_cal_mem.sv
module pcm_cal_mem #(
  parameter int DEPTH = 2048,
  parameter int AW    = 11,
  parameter int W     = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pcm_group_buf.sv
module pcm_group_buf #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int W     = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pcm_sdiv.sv
module pcm_sdiv #(
  parameter int NUM_W = 18,
  parameter int DEN_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic signed [NUM_W-1:0] num,
  input  logic        [DEN_W-1:0] den,
  output logic                    busy,
  output logic                    done,
  output logic signed [NUM_W-1:0] quot
);
  localparam int IT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] mag, mag0;
  logic [DEN_W-1:0] rem, den_q;
  logic             neg;
  logic [IT_W-1:0]  it;
  logic [DEN_W:0]   trial;

  assign trial = {rem, mag[NUM_W-1]};
  assign quot  = neg ? -$signed(mag) : $signed(mag);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      mag   <= '0;
      mag0  <= '0;
      rem   <= '0;
      den_q <= '0;
      neg   <= 1'b0;
      it    <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        neg   <= num[NUM_W-1];
        mag   <= num[NUM_W-1] ? $unsigned(~num + 1'b1) : $unsigned(num);
        mag0  <= num[NUM_W-1] ? $unsigned(~num + 1'b1) : $unsigned(num);
        rem   <= '0;
        den_q <= den;
        it    <= IT_W'(NUM_W);
        busy  <= 1'b1;
      end else if (busy) begin
        if (trial >= {1'b0, den_q}) begin
          rem <= DEN_W'(trial - {1'b0, den_q});
          mag <= {mag[NUM_W-2:0], 1'b1};
        end else begin
          rem <= trial[DEN_W-1:0];
          mag <= {mag[NUM_W-2:0], 1'b0};
        end
        it <= it - 1'b1;
        if (it == IT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R2: an accepted start keeps the divider busy on the next cycle
  a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  // R2: quotient magnitude never exceeds dividend magnitude (divisor >= 1)
  a_r2_quot_bound: assert property (@(posedge clk) disable iff (rst)
    done |-> (mag <= mag0));
endmodule

// File: rtl/pixel_cm_sparsifier.sv
module pixel_cm_sparsifier
  import pcm_pkg::*;
#(
  parameter int ROWS       = 32,
  parameter int COLS       = 64,
  parameter int GROUP_ROWS = 4,
  parameter int RAW_W      = 9,
  parameter int OUT_W      = 10,
  parameter int HIT_LSB    = 4,
  parameter int THR_RST    = 3,
  localparam int PIX_AW    = $clog2(ROWS * COLS),
  localparam int COL_W     = $clog2(COLS),
  localparam int ROW_W     = $clog2(ROWS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [PIX_AW-1:0]       cfg_addr,
  input  logic signed [RAW_W-1:0] cfg_ped,
  input  logic                    cfg_mask,
  input  logic                    thr_we,
  input  logic signed [OUT_W-1:0] thr_data,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [RAW_W-1:0] in_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OUT_W-1:0] out_charge,
  output logic [COL_W-1:0]        out_col,
  output logic [ROW_W-1:0]        out_row,
  output logic                    frame_done
);
  localparam int GPIX   = GROUP_ROWS * COLS;
  localparam int NGRP   = ROWS / GROUP_ROWS;
  localparam int GAW    = $clog2(GPIX);
  localparam int GRP_W  = $clog2(NGRP);
  localparam int DIFF_W = RAW_W + 1;
  localparam int SUM_W  = DIFF_W + GAW;
  localparam int CNT_W  = GAW + 1;
  localparam int CH_W   = DIFF_W + 1;
  localparam logic signed [DIFF_W-1:0] HIT_V = DIFF_W'(HIT_LSB);

  pcm_state_e st;
  logic [GRP_W-1:0] grp;
  logic [GAW-1:0]   loc, rp, s1_loc;
  logic             s1_v;
  logic signed [RAW_W-1:0]  s1_raw;
  logic [RAW_W:0]           cal_q;
  logic signed [RAW_W-1:0]  ped_q;
  logic                     mask_q;
  logic signed [DIFF_W-1:0] diff, buf_q, cm;
  logic                     hit, incl;
  logic signed [SUM_W-1:0]  sum;
  logic [CNT_W-1:0]         cnt;
  logic                     div_go, div_busy, div_done;
  logic signed [SUM_W-1:0]  div_q;
  logic signed [CH_W-1:0]   ch;
  logic signed [OUT_W-1:0]  sat_ch, thr_q;
  logic                     keep, adv;
  logic [PIX_AW-1:0]        rp_idx;

  assign in_ready = (st == ST_FILL);

  // Pedestal and mask memory, read one cycle after acceptance
  pcm_cal_mem #(.DEPTH(ROWS * COLS), .AW(PIX_AW), .W(RAW_W + 1)) cal_i (
    .clk  (clk),
    .we   (cfg_we),
    .waddr(cfg_addr),
    .wdata({cfg_mask, cfg_ped}),
    .raddr({grp, loc}),
    .rdata(cal_q)
  );
  assign ped_q  = cal_q[RAW_W-1:0];
  assign mask_q = cal_q[RAW_W];

  assign diff = DIFF_W'(s1_raw) - DIFF_W'(ped_q);
  assign hit  = diff > HIT_V;
  assign incl = s1_v && !mask_q && !hit;

  pcm_group_buf #(.DEPTH(GPIX), .AW(GAW), .W(DIFF_W)) buf_i (
    .clk  (clk),
    .we   (s1_v),
    .waddr(s1_loc),
    .wdata(diff),
    .raddr(rp),
    .rdata(buf_q)
  );

  // Common-mode accumulation over included pixels
  always_ff @(posedge clk) begin
    if (rst || st == ST_RD) begin
      sum <= '0;
      cnt <= '0;
    end else if (incl) begin
      sum <= sum + SUM_W'(diff);
      cnt <= cnt + 1'b1;
    end
  end

  assign div_go = (st == ST_DIV) && (cnt != '0) && !div_busy;

  pcm_sdiv #(.NUM_W(SUM_W), .DEN_W(CNT_W)) div_i (
    .clk  (clk),
    .rst  (rst),
    .start(div_go),
    .num  (sum),
    .den  (cnt),
    .busy (div_busy),
    .done (div_done),
    .quot (div_q)
  );

  // Correction and saturation
  assign ch = CH_W'(buf_q) - CH_W'(cm);
  generate
    if (OUT_W >= CH_W) begin : g_wide
      assign sat_ch = OUT_W'(ch);
    end else begin : g_clamp
      localparam logic signed [CH_W-1:0] SMAX = CH_W'((2 ** (OUT_W - 1)) - 1);
      localparam logic signed [CH_W-1:0] SMIN = CH_W'(-(2 ** (OUT_W - 1)));
      assign sat_ch = (ch > SMAX) ? OUT_W'(SMAX) :
                      (ch < SMIN) ? OUT_W'(SMIN) : OUT_W'(ch);
    end
  endgenerate

  assign keep   = sat_ch > thr_q;
  assign adv    = (st == ST_EV && !keep) || (st == ST_OUT && out_ready);
  assign rp_idx = {grp, rp};

  always_ff @(posedge clk) begin
    if (rst) thr_q <= OUT_W'(THR_RST);
    else if (thr_we) thr_q <= thr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_FILL;
      grp        <= '0;
      loc        <= '0;
      rp         <= '0;
      s1_v       <= 1'b0;
      s1_raw     <= '0;
      s1_loc     <= '0;
      cm         <= '0;
      out_valid  <= 1'b0;
      out_charge <= '0;
      out_col    <= '0;
      out_row    <= '0;
      frame_done <= 1'b0;
    end else begin
      s1_v       <= 1'b0;
      frame_done <= 1'b0;
      case (st)
        ST_FILL: if (in_valid) begin
          s1_v   <= 1'b1;
          s1_raw <= in_data;
          s1_loc <= loc;
          loc    <= loc + 1'b1;
          if (loc == GAW'(GPIX - 1)) st <= ST_LAST;
        end
        ST_LAST: st <= ST_DIV;
        ST_DIV: begin
          if (cnt == '0) begin
            cm <= '0;
            st <= ST_RD;
          end else begin
            st <= ST_WAIT;
          end
        end
        ST_WAIT: if (div_done) begin
          cm <= div_q[DIFF_W-1:0];
          st <= ST_RD;
        end
        ST_RD: st <= ST_EV;
        ST_EV: if (keep) begin
          out_valid  <= 1'b1;
          out_charge <= sat_ch;
          out_row    <= rp_idx[PIX_AW-1:COL_W];
          out_col    <= rp_idx[COL_W-1:0];
          st         <= ST_OUT;
        end
        ST_OUT: if (out_ready) out_valid <= 1'b0;
        default: st <= ST_FILL;
      endcase
      if (adv) begin
        if (rp == GAW'(GPIX - 1)) begin
          rp <= '0;
          st <= ST_FILL;
          if (grp == GRP_W'(NGRP - 1)) begin
            grp        <= '0;
            frame_done <= 1'b1;
          end else begin
            grp <= grp + 1'b1;
          end
        end else begin
          rp <= rp + 1'b1;
          st <= ST_RD;
        end
      end
    end
  end

  // R11: a pending digit is held until taken
  a_r11_hold_valid: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid);
  a_r11_hold_data: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      ($stable(out_charge) && $stable(out_col) && $stable(out_row)));
  // R6: every presented digit lies above the threshold
  a_r6_above_thr: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_charge > thr_q));
  // R9: no input accepted while a digit is pending
  a_r9_no_input_on_out: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);
  // R10: end-of-frame is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);
  // R5: an empty band yields zero common mode
  a_r5_zero_cm: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DIV && cnt == '0) |=> (cm == '0));
endmodule

// File: tb/pixel_cm_sparsifier_tb_top.sv
module pixel_cm_sparsifier_tb_top;
  localparam int ROWS = 8, COLS = 4, GR = 4, RAW_W = 9, OUT_W = 10;
  localparam int PIX = ROWS * COLS, GPIX = GR * COLS, NGRP = ROWS / GR;
  localparam int AW = $clog2(PIX), CW = $clog2(COLS), RW = $clog2(ROWS);
  localparam int SMAX = 2 ** (OUT_W - 1) - 1, SMIN = -(2 ** (OUT_W - 1));

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 0, cfg_mask = 0, thr_we = 0, in_valid = 0, out_ready = 0;
  logic [AW-1:0] cfg_addr = '0;
  logic signed [RAW_W-1:0] cfg_ped = '0, in_data = '0;
  logic signed [OUT_W-1:0] thr_data = '0;
  logic in_ready, out_valid, frame_done;
  logic signed [OUT_W-1:0] out_charge;
  logic [CW-1:0] out_col;
  logic [RW-1:0] out_row;

  int checks = 0, failures = 0, thr = 3, cyc = 0;
  bit finished = 0;
  int ped[PIX], msk[PIX], raw[PIX];
  int e_ch[PIX], e_col[PIX], e_row[PIX], n_exp;
  int g_ch[PIX], g_col[PIX], g_row[PIX], n_got;
  int lcg = 12345;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  pixel_cm_sparsifier #(.ROWS(ROWS), .COLS(COLS), .GROUP_ROWS(GR),
    .RAW_W(RAW_W), .OUT_W(OUT_W)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_ped(cfg_ped), .cfg_mask(cfg_mask), .thr_we(thr_we),
    .thr_data(thr_data), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_charge(out_charge), .out_col(out_col), .out_row(out_row),
    .frame_done(frame_done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd(input int m);
    lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
    return (lcg >> 8) % m;
  endfunction

  task automatic load_cfg();
    for (int k = 0; k < PIX; k++) begin
      @(negedge clk);
      cfg_we = 1; cfg_addr = AW'(k); cfg_ped = RAW_W'(ped[k]); cfg_mask = msk[k][0];
    end
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic set_thr(input int t);
    @(negedge clk); thr_we = 1; thr_data = OUT_W'(t);
    @(negedge clk); thr_we = 0; thr = t;
  endtask

  // Arithmetic model of R2..R8
  task automatic build_expect();
    n_exp = 0;
    for (int g = 0; g < NGRP; g++) begin
      int s = 0, c = 0, cmv, d, q;
      for (int j = 0; j < GPIX; j++) begin
        d = raw[g*GPIX+j] - ped[g*GPIX+j];
        if (msk[g*GPIX+j] == 0 && d <= 4) begin s += d; c++; end
      end
      cmv = (c == 0) ? 0 : s / c;
      for (int j = 0; j < GPIX; j++) begin
        int k = g * GPIX + j;
        q = raw[k] - ped[k] - cmv;
        if (q > SMAX) q = SMAX;
        if (q < SMIN) q = SMIN;
        if (q > thr) begin
          e_ch[n_exp] = q; e_col[n_exp] = k % COLS; e_row[n_exp] = k / COLS;
          n_exp++;
        end
      end
    end
  endtask

  task automatic run_frame(input int bp, input string tag);
    build_expect();
    n_got = 0;
    fork
      begin
        for (int k = 0; k < PIX; k++) begin
          @(negedge clk);
          while (!in_ready) @(negedge clk);
          in_valid = 1; in_data = RAW_W'(raw[k]);
        end
        @(negedge clk); in_valid = 0;
      end
      begin
        bit fin = 0;
        while (!fin) begin
          @(negedge clk);
          out_ready = (bp == 0) ? 1'b1 : ((cyc % 3) != 0);
          if (out_valid) begin
            chk(in_ready == 0, "R9 in_ready low with digit pending", int'(in_ready), 0);
            if (out_ready) begin
              g_ch[n_got] = out_charge; g_col[n_got] = out_col; g_row[n_got] = out_row;
              n_got++;
            end
          end
          if (frame_done) fin = 1;
        end
      end
    join
    chk(n_got == n_exp, {"R6/R10 digit count before frame_done ", tag}, n_got, n_exp);
    for (int i = 0; i < n_got && i < n_exp; i++) begin
      chk(g_ch[i] == e_ch[i], {"R2/R8 charge ", tag}, g_ch[i], e_ch[i]);
      chk(g_col[i] == e_col[i], {"R7 column ", tag}, g_col[i], e_col[i]);
      chk(g_row[i] == e_row[i], {"R7 row ", tag}, g_row[i], e_row[i]);
    end
    @(negedge clk);
    chk(frame_done == 0, "R10 frame_done single pulse", int'(frame_done), 0);
    chk(in_ready == 1, "R9 ready for next frame", int'(in_ready), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk(out_valid == 0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(frame_done == 0, "R1 frame_done after reset", int'(frame_done), 0);
    chk(in_ready == 1, "R1 in_ready after reset", int'(in_ready), 1);

    // Frame A: small noise, group offsets, hits, masks, d=4 and d=5 edges (R2,R3,R4, default threshold R1/R6)
    for (int k = 0; k < PIX; k++) begin
      ped[k] = ((k * 37) % 61) - 30;
      msk[k] = (k % 7 == 3) ? 1 : 0;
      raw[k] = ped[k] + ((k * 13) % 7) - 3 + ((k / GPIX) * 3 - 1);
    end
    raw[5] = ped[5] + 4;  raw[6] = ped[6] + 5;  raw[20] = ped[20] + 40;
    raw[10] = ped[10] + 9; raw[24] = ped[24] + 4; raw[3] = ped[3] + 30;
    load_cfg();
    run_frame(0, "frameA");

    // Same data, threshold 0, with backpressure (R6, R11)
    set_thr(0);
    run_frame(1, "frameA thr0");

    // R5: band 0 fully masked, band 1 fully hit
    for (int k = 0; k < PIX; k++) begin
      ped[k] = (k % 11) - 5;
      msk[k] = (k < GPIX) ? 1 : 0;
      raw[k] = (k < GPIX) ? ped[k] + (k % 5) - 1 : ped[k] + 6 + (k % 3);
    end
    load_cfg();
    set_thr(3);
    run_frame(0, "R5 empty bands");

    // R8: positive saturation through a large negative common mode
    for (int k = 0; k < PIX; k++) begin
      ped[k] = 255; msk[k] = 0; raw[k] = -256;
    end
    ped[2] = -256; raw[2] = 255;
    ped[GPIX + 7] = -256; raw[GPIX + 7] = 255;
    load_cfg();
    run_frame(1, "R8 saturation");

    // Pseudo-random sweeps at several thresholds with and without backpressure
    for (int f = 0; f < 6; f++) begin
      for (int k = 0; k < PIX; k++) begin
        ped[k] = rnd(201) - 100;
        msk[k] = (rnd(5) == 0) ? 1 : 0;
        raw[k] = ped[k] + rnd(21) - 10 + ((rnd(6) == 0) ? rnd(60) : 0);
      end
      load_cfg();
      set_thr((f % 3) * 5 - 2);
      run_frame(f % 2, "sweep");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule